// File: doc/BRIEF.md
# Tearing-Effect Frame Start Trigger

This block turns the tearing-effect signal from a display panel into a single start strobe for a frame transfer. The panel signal is brought into the clock domain through a two-stage synchronizer. The block then measures how long each pulse stays at its active level. When the pulse ends, its width decides what it is: a long pulse is a vertical sync, a medium pulse is a horizontal sync, and anything shorter is dropped as a glitch.

A two-bit source select chooses between three ways of starting a transfer. The first is an internal start, which fires as soon as the transfer enable rises. The second is a dual-sync mode, in which both sync kinds share the one wire. In this mode each vertical sync clears a line counter, each horizontal sync advances it, and the strobe fires on the line chosen by software. The third is a vertical-only mode, which fires at the end of every qualifying vertical sync. In both sync modes the strobe must first be armed by a rising transfer enable. It fires once and then disarms.

Top module: `tear_trigger`

## Requirements
- R1: After reset `startTrig` is low, nothing is armed and the line counter is invalid. A horizontal-width pulse seen before any vertical sync never causes a trigger.
- R2: With `trigMode` = 0 (internal), `startTrig` is high for exactly one cycle, on the first clock edge after `xferEnable` is sampled rising. A level held high gives no further pulse.
- R3: With `trigMode` = 1, a pulse whose synchronized active width is at least `vsWidth` is a vertical sync. A pulse at least `hsWidth` wide but shorter than `vsWidth` is a horizontal sync. A shorter pulse is ignored. This assumes `vsWidth` > `hsWidth`.
- R4: With `trigMode` = 1, a vertical sync sets the line count to 0 and each horizontal sync adds 1, saturating at 2047. The trigger fires on the sync event that makes the count equal `lineTarget`. A target of 0 fires on the vertical sync itself.
- R5: With `trigMode` = 2, the trigger fires at the end of a pulse of at least `vsWidth`. Shorter pulses have no effect.
- R6: In modes 1 and 2 a trigger needs arming by a rising `xferEnable`. It fires at most once per arming. `xferEnable` low disarms the block.
- R7: The wire is measured at the level given by `hsActiveHigh` in mode 1 and by `vsActiveHigh` in mode 2. A value of 1 means active-high and 0 means active-low.
- R8: A sync-mode trigger rises on the third clock edge, counting the first edge that samples `teIn` inactive as the first.
- R9: With `trigMode` = 3, `startTrig` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| teIn | input | 1 | Asynchronous tearing-effect wire from the panel |
| trigMode | input | 2 | 0 internal, 1 dual sync, 2 vertical only, 3 off |
| vsActiveHigh | input | 1 | Active level of the wire in mode 2 |
| hsActiveHigh | input | 1 | Active level of the wire in mode 1 |
| vsWidth | input | PULSE_W | Minimum width of a vertical sync, in cycles |
| hsWidth | input | PULSE_W | Minimum width of a horizontal sync, in cycles |
| lineTarget | input | LINE_W | Line number on which mode 1 fires |
| xferEnable | input | 1 | Transfer enable; its rise arms or starts the transfer |
| startTrig | output | 1 | One-cycle frame start strobe |

## Verification
An internal start is due one edge after the enable rise. A sync-mode start is due three edges after the first edge that samples the wire inactive. The bench keeps the cycle count of every pulse end and every strobe, and checks that difference exactly. Every other result is checked only after a gap of six idle cycles, which is longer than the three-edge latency. Before each gap the bench records how many pulses are complete, so each strobe can be credited to the pulse that caused it.

// File: rtl/tear_pkg.sv
package tear_pkg;
  typedef enum logic [1:0] {
    SRC_INTERNAL = 2'd0,
    SRC_DUAL     = 2'd1,
    SRC_VONLY    = 2'd2,
    SRC_OFF      = 2'd3
  } trigSrc_e;

  typedef struct packed {
    logic actHigh;
    logic lineClr;
    logic lineInc;
  } dpCtl_t;
endpackage

// File: rtl/tear_datapath.sv
module tear_datapath
  import tear_pkg::*;
#(
  parameter int PULSE_W = 6,
  parameter int LINE_W  = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               teIn,
  input  dpCtl_t             ctl,
  input  logic [PULSE_W-1:0] vsWidth,
  input  logic [PULSE_W-1:0] hsWidth,
  output logic               vsEv,
  output logic               hsEv,
  output logic [LINE_W-1:0]  lineCnt,
  output logic               lineValid
);
  localparam logic [PULSE_W-1:0] PCNT_MAX = {PULSE_W{1'b1}};
  localparam logic [LINE_W-1:0]  LINE_MAX = {LINE_W{1'b1}};

  logic [1:0]         syncQ;
  logic               active;
  logic               prevActive;
  logic [PULSE_W-1:0] pulseCnt;
  logic               pulseEnd;
  logic               longEnough;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b00;
    else       syncQ <= {syncQ[0], teIn};
  end

  assign active = (syncQ[1] == ctl.actHigh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      pulseCnt   <= '0;
    end else begin
      prevActive <= active;
      if (!active)                  pulseCnt <= '0;
      else if (pulseCnt != PCNT_MAX) pulseCnt <= pulseCnt + 1'b1;
    end
  end

  assign pulseEnd   = prevActive && !active;
  assign longEnough = (pulseCnt >= vsWidth);
  assign vsEv       = pulseEnd && longEnough;
  assign hsEv       = pulseEnd && !longEnough && (pulseCnt >= hsWidth);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt   <= '0;
      lineValid <= 1'b0;
    end else if (ctl.lineClr) begin
      lineCnt   <= '0;
      lineValid <= 1'b1;
    end else if (ctl.lineInc && lineCnt != LINE_MAX) begin
      lineCnt <= lineCnt + 1'b1;
    end
  end

  a_r3_width_restart: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (pulseCnt == '0));
  a_r4_line_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lineClr |=> (lineCnt == '0) && lineValid);
  a_r4_line_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineInc && !ctl.lineClr && lineCnt != LINE_MAX) |=> (lineCnt == $past(lineCnt) + 1'b1));
endmodule

// File: rtl/tear_control.sv
module tear_control
  import tear_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        trigMode,
  input  logic              vsActiveHigh,
  input  logic              hsActiveHigh,
  input  logic [LINE_W-1:0] lineTarget,
  input  logic              xferEnable,
  input  logic              vsEv,
  input  logic              hsEv,
  input  logic [LINE_W-1:0] lineCnt,
  input  logic              lineValid,
  output dpCtl_t            ctl,
  output logic              startTrig
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  trigSrc_e          src;
  logic              enQ;
  logic              enRise;
  logic              armed;
  logic              hit;
  logic [LINE_W-1:0] nextLine;

  assign src      = trigSrc_e'(trigMode);
  assign enRise   = xferEnable && !enQ;
  assign nextLine = lineCnt + 1'b1;

  always_comb begin
    ctl.actHigh = (src == SRC_DUAL) ? hsActiveHigh : vsActiveHigh;
    ctl.lineClr = vsEv && (src == SRC_DUAL);
    ctl.lineInc = hsEv && (src == SRC_DUAL) && lineValid;
  end

  always_comb begin
    unique case (src)
      SRC_INTERNAL: hit = enRise;
      SRC_DUAL:     hit = armed && ((vsEv && lineTarget == '0) ||
                          (hsEv && lineValid && lineCnt != LINE_MAX && nextLine == lineTarget));
      SRC_VONLY:    hit = armed && vsEv;
      default:      hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ       <= 1'b0;
      armed     <= 1'b0;
      startTrig <= 1'b0;
    end else begin
      enQ       <= xferEnable;
      startTrig <= hit;
      if (!xferEnable)  armed <= 1'b0;
      else if (enRise)  armed <= 1'b1;
      else if (hit)     armed <= 1'b0;
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    startTrig |=> !startTrig);
  a_r6_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    (startTrig && $past(trigMode) != SRC_INTERNAL) |-> ($past(armed) && !armed));
  a_r9_off_silent: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode == SRC_OFF) |=> !startTrig);
endmodule

// File: rtl/tear_trigger.sv
module tear_trigger
  import tear_pkg::*;
#(
  parameter int PULSE_W = 6,
  parameter int LINE_W  = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               teIn,
  input  logic [1:0]         trigMode,
  input  logic               vsActiveHigh,
  input  logic               hsActiveHigh,
  input  logic [PULSE_W-1:0] vsWidth,
  input  logic [PULSE_W-1:0] hsWidth,
  input  logic [LINE_W-1:0]  lineTarget,
  input  logic               xferEnable,
  output logic               startTrig
);
  dpCtl_t            ctl;
  logic              vsEv;
  logic              hsEv;
  logic [LINE_W-1:0] lineCnt;
  logic              lineValid;

  tear_datapath #(.PULSE_W(PULSE_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .teIn(teIn), .ctl(ctl),
    .vsWidth(vsWidth), .hsWidth(hsWidth),
    .vsEv(vsEv), .hsEv(hsEv), .lineCnt(lineCnt), .lineValid(lineValid)
  );

  tear_control #(.LINE_W(LINE_W)) u_ctl (
    .clk(clk), .rstN(rstN), .trigMode(trigMode),
    .vsActiveHigh(vsActiveHigh), .hsActiveHigh(hsActiveHigh),
    .lineTarget(lineTarget), .xferEnable(xferEnable),
    .vsEv(vsEv), .hsEv(hsEv), .lineCnt(lineCnt), .lineValid(lineValid),
    .ctl(ctl), .startTrig(startTrig)
  );
endmodule

// File: tb/test_tear_trigger.sv
module test_tear_trigger;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        teIn = 1'b0;
  logic [1:0]  trigMode = 2'd0;
  logic        vsActiveHigh = 1'b1;
  logic        hsActiveHigh = 1'b1;
  logic [5:0]  vsWidth = 6'd8;
  logic [5:0]  hsWidth = 6'd3;
  logic [10:0] lineTarget = 11'd0;
  logic        xferEnable = 1'b0;
  logic        startTrig;

  int cyc = 0, fires = 0, fireCyc = 0, fireIdx = -1, pulsesDone = 0, endCyc = 0;
  int checks = 0, failures = 0;
  logic drvHigh = 1'b1;
  bit done = 1'b0;

  tear_trigger i_tear_trigger (
    .clk(clk), .rstN(rstN), .teIn(teIn), .trigMode(trigMode),
    .vsActiveHigh(vsActiveHigh), .hsActiveHigh(hsActiveHigh),
    .vsWidth(vsWidth), .hsWidth(hsWidth), .lineTarget(lineTarget),
    .xferEnable(xferEnable), .startTrig(startTrig)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rstN && startTrig) begin
    fires   = fires + 1;
    fireCyc = cyc;
    fireIdx = pulsesDone - 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int w, input int g);
    @(negedge clk) teIn = drvHigh;
    repeat (w) @(negedge clk);
    teIn = ~drvHigh;
    endCyc = cyc;
    pulsesDone++;
    idle(g);
  endtask

  task automatic cfg(input int mode, input bit vh, input bit hh, input int tgt, input bit drv);
    @(negedge clk) xferEnable = 1'b0;
    trigMode = 2'(mode); vsActiveHigh = vh; hsActiveHigh = hh;
    lineTarget = 11'(tgt); drvHigh = drv; teIn = ~drv;
    idle(6);
    pulsesDone = 0; fireIdx = -1;
  endtask

  task automatic arm();
    @(negedge clk) xferEnable = 1'b1;
    idle(2);
  endtask

  task automatic frame(input int nh);
    pulse(9, 6);
    for (int k = 0; k < nh; k++) pulse(4, 6);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int f0;
    idle(4);
    chk("R1 startTrig in reset", int'(startTrig), 0);
    @(negedge clk) rstN = 1'b1;
    idle(3);
    chk("R1 startTrig after reset", int'(startTrig), 0);

    // R1: no vertical sync seen yet, so horizontal pulses cannot reach a target
    cfg(1, 1, 1, 1, 1); arm(); f0 = fires;
    pulse(4, 8); pulse(4, 8);
    chk("R1 no trigger before first vsync", fires - f0, 0);

    // R2: internal start
    cfg(0, 1, 1, 0, 1); f0 = fires;
    @(negedge clk) xferEnable = 1'b1;
    @(negedge clk) chk("R2 strobe one edge after enable", int'(startTrig), 1);
    @(negedge clk) chk("R2 strobe one cycle long", int'(startTrig), 0);
    idle(10);
    chk("R2 single strobe per rise", fires - f0, 1);
    @(negedge clk) xferEnable = 1'b0; idle(2);
    @(negedge clk) xferEnable = 1'b1; idle(4);
    chk("R2 second rise gives second strobe", fires - f0, 2);

    // R4: sweep line targets over a frame of six horizontal syncs
    for (int t = 0; t <= 7; t++) begin
      cfg(1, 1, 1, t, 1); arm(); f0 = fires;
      frame(6);
      chk($sformatf("R4 fire count target %0d", t), fires - f0, (t <= 6) ? 1 : 0);
      if (t <= 6) chk($sformatf("R4 fire line target %0d", t), fireIdx, t);
    end

    // R6: one trigger per arming across two frames
    cfg(1, 1, 1, 2, 1); arm(); f0 = fires;
    frame(4); frame(4);
    chk("R6 once per arming", fires - f0, 1);

    // R3: classification by width, mode 1, target 1
    for (int w = 1; w <= 10; w++) begin
      cfg(1, 1, 1, 1, 1); arm(); f0 = fires;
      pulse(9, 6); pulse(w, 8);
      chk($sformatf("R3 width %0d", w), fires - f0, (w >= 3 && w < 8) ? 1 : 0);
    end

    // R5: vertical-only mode, width sweep
    for (int w = 1; w <= 10; w++) begin
      cfg(2, 1, 1, 0, 1); arm(); f0 = fires;
      pulse(w, 8);
      chk($sformatf("R5 width %0d", w), fires - f0, (w >= 8) ? 1 : 0);
    end
    cfg(2, 1, 1, 0, 1); arm(); f0 = fires;
    pulse(4, 6); pulse(5, 6); pulse(9, 6);
    chk("R5 short pulses ignored", fires - f0, 1);
    chk("R5 fires on the vsync pulse", fireIdx, 2);

    // R8: exact latency
    cfg(2, 1, 1, 0, 1); arm();
    pulse(9, 8);
    chk("R8 edges from pulse end to strobe", fireCyc - endCyc, 3);

    // R7: polarity selection per mode
    cfg(1, 1, 0, 2, 0); arm(); f0 = fires;
    frame(4);
    chk("R7 mode1 active-low count", fires - f0, 1);
    chk("R7 mode1 active-low line", fireIdx, 2);
    cfg(2, 0, 1, 0, 0); arm(); f0 = fires;
    pulse(9, 8);
    chk("R7 mode2 active-low", fires - f0, 1);

    // R6: arming rules
    cfg(2, 1, 1, 0, 1); f0 = fires;
    pulse(9, 8);
    chk("R6 no trigger without enable", fires - f0, 0);
    arm(); @(negedge clk) xferEnable = 1'b0; idle(2);
    pulse(9, 8);
    chk("R6 enable low disarms", fires - f0, 0);
    arm(); pulse(9, 8); pulse(9, 8);
    chk("R6 single fire while armed", fires - f0, 1);

    // R9: mode 3 never fires
    cfg(3, 1, 1, 0, 1); f0 = fires;
    @(negedge clk) xferEnable = 1'b1; idle(3);
    frame(3); pulse(9, 8);
    chk("R9 mode 3 silent", fires - f0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule